// File: doc/BRIEF.md
# Multi-Board Event Frame Formatter

This block turns one trigger into one event package on a 32-bit word stream with a valid/ready handshake. The samples come from a buffer outside the block that holds up to `N_BOARDS` six-channel boards of 10-bit samples. The block drives a board number and a sample index. The buffer returns all six channel values of that board and sample in the same cycle, and the block packs them into words.

A package starts with an opening control word and ends with a closing control word. Between them, each board contributes two frames. The first frame of a board carries the odd channels 1, 3 and 5. The second carries the even channels 2, 4 and 6. A frame is a header word, then a number of data words set by the sample count, then a checksum word. Each data word holds three samples, a zero type flag and an even-parity bit. Because header, checksum and control words all have bit 31 set, a receiver can always tell them apart from data words.

Top module: `evt_frame_fmt`

## Requirements
- R1: After reset `out_valid` is low, and it stays low until a trigger arrives.
- R2: An event package has exactly 2 + 2·N_BOARDS·(S+2) words, where S is the effective sample count. The package is the opening control word, then every frame, then the closing control word.
- R3: Frames go in board order 0 to N_BOARDS-1, with the odd-channel frame of each board before its even-channel frame. The header word is bits 31:28 = 4'hA, bits 27:20 = board number, bit 16 = 1 for the even-channel frame, bits 7:0 = S, and all other bits zero.
- R4: A data word has bit 31 = 0. In the odd frame, bits 29:20, 19:10 and 9:0 hold channels 1, 3 and 5. In the even frame they hold channels 2, 4 and 6. Channel c (1..6) is found at `samp_data[(c-1)*10 +: 10]`.
- R5: Bit 30 of a data word makes the count of ones in bits 30:0 even.
- R6: The checksum word is {1'b1, T[30:0]}, where T is the modulo-2^32 sum of the frame's header word and all of its data words.
- R7: The opening control word is 32'hF0A5_0001 and the closing control word is 32'hF0A5_00FE.
- R8: While `out_valid` is high and `out_ready` is low, the output word holds steady. No word is dropped or repeated.
- R9: A trigger in the idle state makes `out_valid` go high on the next cycle. A trigger during an event is ignored. After the closing word is accepted, `out_valid` is low on the next cycle.
- R10: `cfg_nsamp` is captured when the trigger is accepted. Later changes do not affect the event in flight.
- R11: S = min(`cfg_nsamp`, MAX_SAMPLES). When S = 0, each header word is followed directly by the checksum word.
- R12: Data word k (from 0) of a frame uses sample index k of that frame's board. While a data word is presented, `samp_board` and `samp_idx` show that board and index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Start an event package (honoured only when idle) |
| cfg_nsamp | input | CNT_W | Requested data words per frame |
| samp_board | output | BRD_W | Board being read from the sample buffer |
| samp_idx | output | CNT_W | Sample index being read |
| samp_data | input | 60 | Six 10-bit channel values for the addressed board and index |
| out_data | output | 32 | Output word |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Sink accepts the word |

## Verification
A wrong board, frame or sample counter shows up in the very next header or data word. A data word from the wrong board, index or channel group does not match the bench's arithmetic sample model. A wrong header field does not match the expected header. A corrupted checksum accumulator is caught at the end of the frame it affects. Sequencing faults show at the end of the event: a skipped or repeated word, or a missed stall, changes the word count or shifts every later word. A sequencer that fails to return to idle keeps `out_valid` high in the cycle after the closing word.

// File: rtl/efmt_pkg.sv
package efmt_pkg;

    localparam int SAMP_W        = 10;
    localparam int CH_PER_BOARD  = 6;
    localparam int LANES         = 3;
    localparam int WORD_W        = 32;

    localparam logic [WORD_W-1:0] OPEN_WORD  = 32'hF0A5_0001;
    localparam logic [WORD_W-1:0] CLOSE_WORD = 32'hF0A5_00FE;
    localparam logic [3:0]        HDR_TAG    = 4'hA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_HDR,
        ST_DATA,
        ST_CSUM,
        ST_CLOSE
    } efmt_state_e;

    typedef struct packed {
        logic [SAMP_W-1:0] first;
        logic [SAMP_W-1:0] second;
        logic [SAMP_W-1:0] third;
    } efmt_triplet_t;

    function automatic logic [WORD_W-1:0] make_data(input efmt_triplet_t t);
        return {1'b0, ^t, t};
    endfunction

    function automatic logic [WORD_W-1:0] make_hdr(input logic [7:0] brd,
                                                   input logic       even_frame,
                                                   input logic [7:0] cnt);
        return {HDR_TAG, brd, 3'b000, even_frame, 8'h00, cnt};
    endfunction

    function automatic logic [WORD_W-1:0] make_csum(input logic [WORD_W-1:0] acc);
        return {1'b1, acc[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/efmt_seq.sv
module efmt_seq
    import efmt_pkg::*;
#(
    parameter int N_BOARDS    = 4,
    parameter int MAX_SAMPLES = 16,
    localparam int BRD_W = (N_BOARDS > 1) ? $clog2(N_BOARDS) : 1,
    localparam int CNT_W = $clog2(MAX_SAMPLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic [CNT_W-1:0] cfg_nsamp,
    input  logic             fire,
    output efmt_state_e      st_q,
    output logic [BRD_W-1:0] board_q,
    output logic             even_q,
    output logic [CNT_W-1:0] idx_q,
    output logic [CNT_W-1:0] nsamp_q
);

    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(MAX_SAMPLES);
    localparam logic [BRD_W-1:0] LAST_BRD  = BRD_W'(N_BOARDS - 1);

    logic [CNT_W-1:0] nsamp_clamped;

    always_comb begin
        nsamp_clamped = (cfg_nsamp > CNT_MAX) ? CNT_MAX : cfg_nsamp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            board_q <= '0;
            even_q  <= 1'b0;
            idx_q   <= '0;
            nsamp_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (trig) begin
                        nsamp_q <= nsamp_clamped;
                        st_q    <= ST_OPEN;
                    end
                end
                ST_OPEN: begin
                    if (fire) begin
                        board_q <= '0;
                        even_q  <= 1'b0;
                        st_q    <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (fire) begin
                        idx_q <= '0;
                        st_q  <= (nsamp_q == '0) ? ST_CSUM : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (fire) begin
                        if (idx_q == nsamp_q - CNT_W'(1)) begin
                            st_q <= ST_CSUM;
                        end else begin
                            idx_q <= idx_q + CNT_W'(1);
                        end
                    end
                end
                ST_CSUM: begin
                    if (fire) begin
                        if (even_q) begin
                            if (board_q == LAST_BRD) begin
                                st_q <= ST_CLOSE;
                            end else begin
                                board_q <= board_q + BRD_W'(1);
                                even_q  <= 1'b0;
                                st_q    <= ST_HDR;
                            end
                        end else begin
                            even_q <= 1'b1;
                            st_q   <= ST_HDR;
                        end
                    end
                end
                ST_CLOSE: begin
                    if (fire) begin
                        st_q <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/efmt_word.sv
module efmt_word
    import efmt_pkg::*;
#(
    parameter int N_BOARDS    = 4,
    parameter int MAX_SAMPLES = 16,
    localparam int BRD_W = (N_BOARDS > 1) ? $clog2(N_BOARDS) : 1,
    localparam int CNT_W = $clog2(MAX_SAMPLES + 1),
    localparam int ROW_W = CH_PER_BOARD * SAMP_W
) (
    input  efmt_state_e        st,
    input  logic [BRD_W-1:0]   board,
    input  logic               even_frame,
    input  logic [CNT_W-1:0]   nsamp,
    input  logic [ROW_W-1:0]   row,
    input  logic [WORD_W-1:0]  acc,
    output logic [WORD_W-1:0]  word
);

    logic [SAMP_W-1:0] lane [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane[k] = even_frame ? row[(2*k+1)*SAMP_W +: SAMP_W]
                                    : row[(2*k)*SAMP_W   +: SAMP_W];
    end

    efmt_triplet_t trip;

    always_comb begin
        trip.first  = lane[0];
        trip.second = lane[1];
        trip.third  = lane[2];
    end

    always_comb begin
        case (st)
            ST_OPEN:  word = OPEN_WORD;
            ST_HDR:   word = make_hdr(8'(board), even_frame, 8'(nsamp));
            ST_DATA:  word = make_data(trip);
            ST_CSUM:  word = make_csum(acc);
            ST_CLOSE: word = CLOSE_WORD;
            default:  word = '0;
        endcase
    end

endmodule

// File: rtl/efmt_csum.sv
module efmt_csum
    import efmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              add,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] acc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= word;
        end else if (add) begin
            acc_q <= acc_q + word;
        end
    end

endmodule

// File: rtl/evt_frame_fmt.sv
module evt_frame_fmt
    import efmt_pkg::*;
#(
    parameter int N_BOARDS    = 4,
    parameter int MAX_SAMPLES = 16,
    localparam int BRD_W = (N_BOARDS > 1) ? $clog2(N_BOARDS) : 1,
    localparam int CNT_W = $clog2(MAX_SAMPLES + 1),
    localparam int ROW_W = CH_PER_BOARD * SAMP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [CNT_W-1:0]  cfg_nsamp,
    output logic [BRD_W-1:0]  samp_board,
    output logic [CNT_W-1:0]  samp_idx,
    input  logic [ROW_W-1:0]  samp_data,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);

    efmt_state_e       st_q;
    logic [BRD_W-1:0]  board_q;
    logic              even_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  nsamp_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] word;
    logic              fire;

    assign out_valid  = (st_q != ST_IDLE);
    assign fire       = out_valid & out_ready;
    assign out_data   = word;
    assign samp_board = board_q;
    assign samp_idx   = idx_q;

    efmt_seq #(
        .N_BOARDS    (N_BOARDS),
        .MAX_SAMPLES (MAX_SAMPLES)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .cfg_nsamp (cfg_nsamp),
        .fire      (fire),
        .st_q      (st_q),
        .board_q   (board_q),
        .even_q    (even_q),
        .idx_q     (idx_q),
        .nsamp_q   (nsamp_q)
    );

    efmt_word #(
        .N_BOARDS    (N_BOARDS),
        .MAX_SAMPLES (MAX_SAMPLES)
    ) word_i (
        .st         (st_q),
        .board      (board_q),
        .even_frame (even_q),
        .nsamp      (nsamp_q),
        .row        (samp_data),
        .acc        (acc_q),
        .word       (word)
    );

    efmt_csum csum_i (
        .clk   (clk),
        .rst   (rst),
        .load  (fire && (st_q == ST_HDR)),
        .add   (fire && (st_q == ST_DATA)),
        .word  (word),
        .acc_q (acc_q)
    );

endmodule

// File: rtl/efmt_chk.sv
module efmt_chk
    import efmt_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data,
    input efmt_state_e       st,
    input logic [CNT_W-1:0]  nsamp_q,
    input logic [CNT_W-1:0]  samp_idx
);

    p_hold_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_parity_even_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_data[31]) |-> (^out_data[30:0] == 1'b0));

    p_open_first_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> (out_data == OPEN_WORD));

    p_close_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_CLOSE && out_valid && out_ready) |=> !out_valid);

    p_idx_range_r12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> (samp_idx < nsamp_q));

    p_data_flag_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA) |-> !out_data[31]);

endmodule

bind evt_frame_fmt efmt_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .st        (st_q),
    .nsamp_q   (nsamp_q),
    .samp_idx  (samp_idx)
);

// File: tb/evt_frame_fmt_tb_top.sv
`timescale 1ns/1ps
module evt_frame_fmt_tb_top;

    localparam int NB = 2;
    localparam int MS = 5;
    localparam int BW = 1;
    localparam int CW = 3;

    logic          clk;
    logic          rst;
    logic          trig;
    logic [CW-1:0] cfg_nsamp;
    logic [BW-1:0] samp_board;
    logic [CW-1:0] samp_idx;
    logic [59:0]   samp_data;
    logic [31:0]   out_data;
    logic          out_valid;
    logic          out_ready;

    int seed;
    int n_cmp;
    int n_bad;

    logic [31:0] exp_w [64];
    string       exp_t [64];
    int          n_exp;
    logic [31:0] got_w [64];
    int          n_got;
    logic [15:0] lfsr;

    evt_frame_fmt #(.N_BOARDS(NB), .MAX_SAMPLES(MS)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .cfg_nsamp  (cfg_nsamp),
        .samp_board (samp_board),
        .samp_idx   (samp_idx),
        .samp_data  (samp_data),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    // sample buffer model: channel ch is 1-based
    function automatic logic [9:0] sval(int ev, int b, int i, int ch);
        return 10'(ev * 97 + b * 211 + i * 37 + ch * 53 + ch * i * 29 + 1000);
    endfunction

    always_comb begin
        for (int c = 0; c < 6; c++) begin
            samp_data[c*10 +: 10] = sval(seed, int'(samp_board), int'(samp_idx), c + 1);
        end
    end

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, expv);
        end
    endtask

    task automatic build_exp(input int ns, input int ev);
        int          nc;
        logic [31:0] h;
        logic [31:0] sum;
        logic [29:0] d;
        nc = (ns > MS) ? MS : ns;
        n_exp = 0;
        exp_w[n_exp] = 32'hF0A5_0001; exp_t[n_exp] = "R7 open"; n_exp++;
        for (int b = 0; b < NB; b++) begin
            for (int fb = 0; fb < 2; fb++) begin
                h = 32'hA000_0000 | (32'(b) << 20) | (32'(fb) << 16) | 32'(nc);
                exp_w[n_exp] = h; exp_t[n_exp] = "R3 header"; n_exp++;
                sum = h;
                for (int i = 0; i < nc; i++) begin
                    d = {sval(ev, b, i, fb + 1), sval(ev, b, i, fb + 3), sval(ev, b, i, fb + 5)};
                    exp_w[n_exp] = {1'b0, ^d, d};
                    exp_t[n_exp] = "R4 R12 data";
                    sum = sum + exp_w[n_exp];
                    n_exp++;
                end
                exp_w[n_exp] = {1'b1, sum[30:0]}; exp_t[n_exp] = "R6 checksum"; n_exp++;
            end
        end
        exp_w[n_exp] = 32'hF0A5_00FE; exp_t[n_exp] = "R7 close"; n_exp++;
    endtask

    task automatic run_event(input int ns, input int ev, input bit throttled);
        int          cyc;
        bit          prev_stall;
        logic [31:0] prev_data;
        build_exp(ns, ev);
        @(negedge clk);
        seed      = ev;
        cfg_nsamp = CW'(ns);
        trig      = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        #1;
        check(out_valid == 1'b1, "R9 trigger latency", 32'(out_valid), 32'd1);
        n_got = 0;
        cyc = 0;
        prev_stall = 1'b0;
        prev_data = '0;
        while (n_got < n_exp && cyc < 400) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = throttled ? (lfsr[0] | lfsr[3]) : 1'b1;
            // R9 R10: stray trigger and count changes during the event
            trig      = (cyc == 3 || cyc == 9);
            cfg_nsamp = CW'(lfsr[7:5]);
            #1;
            if (prev_stall) begin
                check(out_valid && out_data == prev_data, "R8 stall hold", out_data, prev_data);
            end
            if (out_valid && out_ready) begin
                got_w[n_got] = out_data;
                n_got++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            cyc++;
            @(negedge clk);
        end
        trig = 1'b0;
        out_ready = 1'b1;
        #1;
        check(out_valid == 1'b0, "R9 idle after close", 32'(out_valid), 32'd0);
        check(n_got == n_exp, (ns > MS) ? "R2 R11 word count clamp" : "R2 word count",
              32'(n_got), 32'(n_exp));
        for (int k = 0; k < n_exp && k < n_got; k++) begin
            check(got_w[k] == exp_w[k], exp_t[k], got_w[k], exp_w[k]);
            if (!got_w[k][31]) begin
                check(got_w[k][30] == ^got_w[k][29:0], "R5 parity",
                      32'(got_w[k][30]), 32'(^got_w[k][29:0]));
            end
        end
    endtask

    initial begin
        n_cmp = 0;
        n_bad = 0;
        seed = 0;
        lfsr = 16'hACE1;
        rst = 1'b1;
        trig = 1'b0;
        cfg_nsamp = '0;
        out_ready = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 reset state", 32'(out_valid), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 idle without trigger", 32'(out_valid), 32'd0);
        // R11: sweep every count including zero and values above the limit
        for (int ns = 0; ns < 8; ns++) begin
            run_event(ns, ns + 1, 1'b0);
        end
        for (int ns = 0; ns < 8; ns++) begin
            run_event(ns, ns + 40, 1'b1);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule